// File: doc/BRIEF.md
# Backplane Transaction Recorder with Cycle Timing

This block watches an asynchronous, strobe-handshaked parallel backplane bus and writes one record into a small buffer each time a data-transfer cycle is terminated, either by the slave's acknowledge or by a bus error. Each record carries a decoded operation type, an addressing-width code, the sampled address and data, a running cycle index and the number of oversampling clock periods the cycle took. With a 100 MHz sampling clock, each unit of duration is 10 ns.

Capture is single-shot. After reset the recorder is armed and stores nothing until a trigger: a terminated cycle whose address, data and address-modifier code match the programmed values under per-bit masks. A bus-error termination always triggers. The triggering cycle is the first record, a programmable number of further cycles follow, and then the recorder stops and raises a done flag. A host drains the buffer in order through a simple read strobe.

All bus inputs are active-low strobes plus address, data and modifier lines. They pass through a synchroniser before any edge is detected.

Top module: `bus_rec_top`

## Requirements
- R1: A record is written only in response to a termination: a high-to-low transition, after synchronisation, of `dtack_n` or `berr_n`. There is at most one record per termination.
- R2: The stored duration is the number of sampling-clock periods from the falling edge of `as_n` to the terminating edge. It saturates at 2^DURW-1 and never wraps. Within one strobe, a second termination measures from the same strobe edge.
- R3: The stored index is 0 for the first termination after reset. It increases by one on every termination, whether that cycle is stored or not.
- R4: The operation code is chosen by the first rule that applies. `iack_n` low gives 6, interrupt acknowledge. `ds_n` high gives 5, address only. `am[1:0]`=3 gives 4, block write, when `write_n` is low, and 3, block read, otherwise. `write_n` low after a read termination under the same address strobe gives 2, read-modify-write. `write_n` low otherwise gives 1, write. Anything else gives 0, read.
- R5: The width code comes from `am[5:3]`: 101→0 (16-bit), 111→1 (24-bit), 001→2 (32-bit), 110→3 (40-bit), 000→4 (64-bit). Any other value gives 7.
- R6: While armed, a termination triggers when every address, data and modifier bit whose mask bit is 1 equals the programmed value. `triggered` rises with the trigger.
- R7: A falling edge on `berr_n` triggers regardless of the match settings.
- R8: Terminations before the trigger are not stored. The triggering cycle is the first record.
- R9: After the trigger, exactly `cfg_post` further terminations are stored. `done` then rises and stays high until reset, and no further record is written.
- R10: `rd_valid` is high while unread records exist. The `rd_*` fields show the oldest unread record, and a cycle with `rd_en` and `rd_valid` high moves on to the next record.
- R11: During and right after reset, `triggered`, `done` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| dtack_n | input | 1 | Transfer acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |
| write_n | input | 1 | Direction, low for write |
| iack_n | input | 1 | Interrupt acknowledge cycle, active low |
| am | input | 6 | Address modifier code |
| addr | input | AW | Bus address |
| data | input | DW | Bus data |
| cfg_addr | input | AW | Address compare value |
| cfg_addr_mask | input | AW | Address compare enables (1 = compare) |
| cfg_data | input | DW | Data compare value |
| cfg_data_mask | input | DW | Data compare enables |
| cfg_am | input | 6 | Modifier compare value |
| cfg_am_mask | input | 6 | Modifier compare enables |
| cfg_post | input | log2(DEPTH) | Records stored after the trigger record |
| rd_en | input | 1 | Host pops the head record |
| rd_valid | output | 1 | Unread record available |
| rd_op | output | 3 | Head record operation code |
| rd_aw | output | 3 | Head record width code |
| rd_addr | output | AW | Head record address |
| rd_data | output | DW | Head record data |
| rd_idx | output | IDXW | Head record cycle index |
| rd_dur | output | DURW | Head record duration |
| triggered | output | 1 | Trigger has occurred |
| done | output | 1 | Post-trigger capture complete |

## Verification
The bench covers cycles that miss the trigger. A recorder that stored them, or that failed to count them, would show a non-empty buffer or wrong indices on the stored records. A bus error is sent with a compare that can never match. A design that did not force the trigger would stay armed. The same error cycle is held far beyond the counter range, so a wrapping duration would read back small instead of all ones. A read followed by a write under one address strobe checks that the second transfer decodes as read-modify-write and keeps timing from the original strobe edge. A cycle sent after completion must not appear in the buffer.

// File: rtl/rec_pkg.sv
package rec_pkg;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_RMW       = 3'd2,
    OP_BLK_RD    = 3'd3,
    OP_BLK_WR    = 3'd4,
    OP_ADDR_ONLY = 3'd5,
    OP_IACK      = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_DONE    = 2'd2
  } cap_state_e;

  localparam logic [2:0] AWC_16  = 3'd0;
  localparam logic [2:0] AWC_24  = 3'd1;
  localparam logic [2:0] AWC_32  = 3'd2;
  localparam logic [2:0] AWC_40  = 3'd3;
  localparam logic [2:0] AWC_64  = 3'd4;
  localparam logic [2:0] AWC_UNK = 3'd7;

  function automatic logic [2:0] aw_decode(input logic [5:0] am);
    case (am[5:3])
      3'b101:  aw_decode = AWC_16;
      3'b111:  aw_decode = AWC_24;
      3'b001:  aw_decode = AWC_32;
      3'b110:  aw_decode = AWC_40;
      3'b000:  aw_decode = AWC_64;
      default: aw_decode = AWC_UNK;
    endcase
  endfunction

  function automatic op_e op_decode(input logic iack_n, input logic ds_n,
                                    input logic write_n, input logic [5:0] am,
                                    input logic rd_seen);
    if (!iack_n)              op_decode = OP_IACK;
    else if (ds_n)            op_decode = OP_ADDR_ONLY;
    else if (am[1:0] == 2'b11) op_decode = write_n ? OP_BLK_RD : OP_BLK_WR;
    else if (!write_n)        op_decode = rd_seen ? OP_RMW : OP_WRITE;
    else                      op_decode = OP_READ;
  endfunction

endpackage

// File: rtl/rec_sync.sv
module rec_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '1;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rec_classify.sv
module rec_classify
  import rec_pkg::*;
#(
  parameter int IDXW = 8,
  parameter int DURW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_n,
  input  logic            ds_n,
  input  logic            dtack_n,
  input  logic            berr_n,
  input  logic            write_n,
  input  logic            iack_n,
  input  logic [5:0]      am,
  output logic            term,
  output logic            berr_fall,
  output logic            as_fall,
  output logic [2:0]      op,
  output logic [2:0]      aw,
  output logic [IDXW-1:0] idx,
  output logic [DURW-1:0] dur
);

  localparam logic [DURW-1:0] DUR_MAX = '1;

  logic            as_q, dtack_q, berr_q;
  logic            run_q, run_d;
  logic            rd_seen_q, rd_seen_d;
  logic [DURW-1:0] dur_q, dur_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            as_rise, dtack_fall;
  op_e             op_now;

  always_comb begin
    as_fall    = as_q & ~as_n;
    as_rise    = ~as_q & as_n;
    dtack_fall = dtack_q & ~dtack_n;
    berr_fall  = berr_q & ~berr_n;
    term       = dtack_fall | berr_fall;
    op_now     = op_decode(iack_n, ds_n, write_n, am, rd_seen_q);

    run_d = run_q;
    if (as_fall)      run_d = 1'b1;
    else if (as_rise) run_d = 1'b0;

    dur_d = dur_q;
    if (as_fall)                        dur_d = DURW'(1);
    else if (run_q && dur_q != DUR_MAX) dur_d = dur_q + 1'b1;

    rd_seen_d = rd_seen_q;
    if (as_fall)                        rd_seen_d = 1'b0;
    else if (term && op_now == OP_READ) rd_seen_d = 1'b1;

    idx_d = idx_q;
    if (term) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q      <= 1'b1;
      dtack_q   <= 1'b1;
      berr_q    <= 1'b1;
      run_q     <= 1'b0;
      rd_seen_q <= 1'b0;
      dur_q     <= '0;
      idx_q     <= '0;
    end else begin
      as_q      <= as_n;
      dtack_q   <= dtack_n;
      berr_q    <= berr_n;
      run_q     <= run_d;
      rd_seen_q <= rd_seen_d;
      dur_q     <= dur_d;
      idx_q     <= idx_d;
    end
  end

  assign op  = op_now;
  assign aw  = aw_decode(am);
  assign idx = idx_q;
  assign dur = dur_q;

endmodule

// File: rtl/rec_trigger.sv
module rec_trigger
  import rec_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          term,
  input  logic          berr_fall,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [5:0]    am,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_addr_mask,
  input  logic [DW-1:0] cfg_data,
  input  logic [DW-1:0] cfg_data_mask,
  input  logic [5:0]    cfg_am,
  input  logic [5:0]    cfg_am_mask,
  input  logic [PW-1:0] cfg_post,
  output logic          wr_en,
  output logic          triggered,
  output logic          done
);

  cap_state_e    state_q, state_d;
  logic [PW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          match;

  always_comb begin
    match = (((addr ^ cfg_addr) & cfg_addr_mask) == '0) &&
            (((data ^ cfg_data) & cfg_data_mask) == '0) &&
            (((am ^ cfg_am) & cfg_am_mask) == '0);
    cnt_inc = cnt_q + 1'b1;
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    case (state_q)
      ST_ARMED: begin
        if (term && (match || berr_fall)) begin
          wr_en   = 1'b1;
          cnt_d   = '0;
          state_d = (cfg_post == '0) ? ST_DONE : ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        if (term) begin
          wr_en = 1'b1;
          cnt_d = cnt_inc;
          if (cnt_inc == cfg_post) state_d = ST_DONE;
        end
      end
      default: begin
        state_d = ST_DONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign triggered = (state_q != ST_ARMED);
  assign done      = (state_q == ST_DONE);

endmodule

// File: rtl/rec_buffer.sv
module rec_buffer #(
  parameter int RW    = 64,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_rec,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [RW-1:0] rd_rec
);

  localparam int PW = $clog2(DEPTH);

  logic [RW-1:0] mem [DEPTH];
  logic [PW:0]   wr_ptr_q, wr_ptr_d;
  logic [PW:0]   rd_ptr_q, rd_ptr_d;
  logic          pop;

  always_comb begin
    rd_valid = (wr_ptr_q != rd_ptr_q);
    pop      = rd_en && rd_valid;
    wr_ptr_d = wr_en ? wr_ptr_q + 1'b1 : wr_ptr_q;
    rd_ptr_d = pop ? rd_ptr_q + 1'b1 : rd_ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q[PW-1:0]] <= wr_rec;
  end

  assign rd_rec = mem[rd_ptr_q[PW-1:0]];

endmodule

// File: rtl/bus_rec_top.sv
module bus_rec_top #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int IDXW        = 8,
  parameter int DURW        = 8,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_n,
  input  logic            ds_n,
  input  logic            dtack_n,
  input  logic            berr_n,
  input  logic            write_n,
  input  logic            iack_n,
  input  logic [5:0]      am,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   data,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [AW-1:0]   cfg_addr_mask,
  input  logic [DW-1:0]   cfg_data,
  input  logic [DW-1:0]   cfg_data_mask,
  input  logic [5:0]      cfg_am,
  input  logic [5:0]      cfg_am_mask,
  input  logic [PW-1:0]   cfg_post,
  input  logic            rd_en,
  output logic            rd_valid,
  output logic [2:0]      rd_op,
  output logic [2:0]      rd_aw,
  output logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [IDXW-1:0] rd_idx,
  output logic [DURW-1:0] rd_dur,
  output logic            triggered,
  output logic            done
);

  localparam int VW = 12 + AW + DW;
  localparam int RW = 6 + AW + DW + IDXW + DURW;

  logic [VW-1:0]   raw_vec, syn_vec;
  logic            s_as_n, s_ds_n, s_dtack_n, s_berr_n, s_write_n, s_iack_n;
  logic [5:0]      s_am;
  logic [AW-1:0]   s_addr;
  logic [DW-1:0]   s_data;
  logic            term, berr_fall, as_fall, wr_en;
  logic [2:0]      op, aw;
  logic [IDXW-1:0] idx;
  logic [DURW-1:0] dur;
  logic [RW-1:0]   wr_rec, rd_rec;

  assign raw_vec = {as_n, ds_n, dtack_n, berr_n, write_n, iack_n, am, addr, data};

  rec_sync #(.W(VW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(syn_vec)
  );

  assign {s_as_n, s_ds_n, s_dtack_n, s_berr_n, s_write_n, s_iack_n,
          s_am, s_addr, s_data} = syn_vec;

  rec_classify #(.IDXW(IDXW), .DURW(DURW)) u_classify (
    .clk(clk), .rst_n(rst_n),
    .as_n(s_as_n), .ds_n(s_ds_n), .dtack_n(s_dtack_n), .berr_n(s_berr_n),
    .write_n(s_write_n), .iack_n(s_iack_n), .am(s_am),
    .term(term), .berr_fall(berr_fall), .as_fall(as_fall),
    .op(op), .aw(aw), .idx(idx), .dur(dur)
  );

  rec_trigger #(.AW(AW), .DW(DW), .PW(PW)) u_trigger (
    .clk(clk), .rst_n(rst_n), .term(term), .berr_fall(berr_fall),
    .addr(s_addr), .data(s_data), .am(s_am),
    .cfg_addr(cfg_addr), .cfg_addr_mask(cfg_addr_mask),
    .cfg_data(cfg_data), .cfg_data_mask(cfg_data_mask),
    .cfg_am(cfg_am), .cfg_am_mask(cfg_am_mask), .cfg_post(cfg_post),
    .wr_en(wr_en), .triggered(triggered), .done(done)
  );

  assign wr_rec = {op, aw, s_addr, s_data, idx, dur};

  rec_buffer #(.RW(RW), .DEPTH(DEPTH)) u_buffer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rec(wr_rec),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_rec(rd_rec)
  );

  assign {rd_op, rd_aw, rd_addr, rd_data, rd_idx, rd_dur} = rd_rec;

endmodule

// File: rtl/rec_checker.sv
module rec_checker #(
  parameter int IDXW = 8,
  parameter int DURW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            term,
  input logic            as_fall,
  input logic            wr_en,
  input logic [IDXW-1:0] idx,
  input logic [DURW-1:0] dur,
  input logic            triggered,
  input logic            done,
  input logic            rd_valid
);

  AST_WR_ONLY_ON_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> term); // R1

  AST_DUR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> (dur >= $past(dur))); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (idx == IDXW'($past(idx) + 1'b1))); // R3

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(idx)); // R3

  AST_NO_EARLY_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> triggered); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R9

  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en); // R9

endmodule

bind bus_rec_top rec_checker #(.IDXW(IDXW), .DURW(DURW)) u_rec_checker (
  .clk(clk), .rst_n(rst_n), .term(term), .as_fall(as_fall), .wr_en(wr_en),
  .idx(idx), .dur(dur), .triggered(triggered), .done(done), .rd_valid(rd_valid)
);

// File: tb/test_bus_rec_top.sv
module test_bus_rec_top;

  localparam int AW = 32, DW = 32, IDXW = 8, DURW = 8, DEPTH = 8;
  localparam int PW = $clog2(DEPTH);

  typedef struct packed {
    logic [5:0]  am;
    logic [31:0] addr;
    logic [31:0] data;
    logic        wr;
    logic        ds_on;
    logic        iack;
    logic        berr;
    logic [9:0]  gap;
    logic [2:0]  op;
    logic [2:0]  aw;
  } vec_t;

  localparam vec_t TABLE [0:7] = '{
    '{6'h09, 32'h2000_0000, 32'h0000_0011, 1'b0, 1'b1, 1'b0, 1'b0, 10'd5, 3'd0, 3'd2},
    '{6'h39, 32'h0000_0010, 32'h0000_0022, 1'b1, 1'b1, 1'b0, 1'b0, 10'd4, 3'd1, 3'd1},
    '{6'h09, 32'h1000_0040, 32'h0000_00AA, 1'b0, 1'b1, 1'b0, 1'b0, 10'd6, 3'd0, 3'd2},
    '{6'h2D, 32'h0000_1234, 32'h0000_0055, 1'b1, 1'b1, 1'b0, 1'b0, 10'd3, 3'd1, 3'd0},
    '{6'h0F, 32'h4000_0100, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0, 1'b0, 10'd7, 3'd3, 3'd2},
    '{6'h13, 32'h5000_0200, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b0, 10'd2, 3'd4, 3'd7},
    '{6'h35, 32'h0000_0003, 32'h0000_0007, 1'b0, 1'b1, 1'b1, 1'b0, 10'd4, 3'd6, 3'd3},
    '{6'h09, 32'h1000_0000, 32'h0000_0099, 1'b0, 1'b1, 1'b0, 1'b0, 10'd5, 3'd0, 3'd2}
  };

  localparam logic [31:0] CA = 32'h1000_0000, CM = 32'hFFFF_0000;
  localparam logic [PW-1:0] POST = PW'(4);

  logic clk, rst_n;
  logic as_n, ds_n, dtack_n, berr_n, write_n, iack_n;
  logic [5:0] am, cfg_am, cfg_am_mask;
  logic [AW-1:0] addr, cfg_addr, cfg_addr_mask;
  logic [DW-1:0] data, cfg_data, cfg_data_mask;
  logic [PW-1:0] cfg_post;
  logic rd_en, rd_valid, triggered, done;
  logic [2:0] rd_op, rd_aw;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [IDXW-1:0] rd_idx;
  logic [DURW-1:0] rd_dur;

  int checks = 0, fails = 0;
  bit finished = 0;

  bus_rec_top i_bus_rec_top (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .dtack_n(dtack_n),
    .berr_n(berr_n), .write_n(write_n), .iack_n(iack_n), .am(am),
    .addr(addr), .data(data), .cfg_addr(cfg_addr), .cfg_addr_mask(cfg_addr_mask),
    .cfg_data(cfg_data), .cfg_data_mask(cfg_data_mask), .cfg_am(cfg_am),
    .cfg_am_mask(cfg_am_mask), .cfg_post(cfg_post), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_op(rd_op), .rd_aw(rd_aw), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_idx(rd_idx), .rd_dur(rd_dur),
    .triggered(triggered), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    as_n = 1'b1; ds_n = 1'b1; dtack_n = 1'b1; berr_n = 1'b1;
    write_n = 1'b1; iack_n = 1'b1;
  endtask

  task automatic bus_cycle(input vec_t v);
    @(negedge clk);
    am = v.am; addr = v.addr; data = v.data;
    write_n = ~v.wr; iack_n = ~v.iack;
    repeat (2) @(negedge clk);
    as_n = 1'b0;
    ds_n = ~v.ds_on;
    repeat (int'(v.gap)) @(negedge clk);
    if (v.berr) berr_n = 1'b0;
    else        dtack_n = 1'b0;
    repeat (6) @(negedge clk);
    idle_bus();
    repeat (6) @(negedge clk);
  endtask

  task automatic read_rec(input string req, input logic [2:0] op,
                          input logic [2:0] aw, input logic [31:0] a,
                          input logic [31:0] d, input logic [7:0] ix,
                          input logic [7:0] du);
    @(negedge clk);
    chk(req, "rd_valid", 64'(rd_valid), 64'd1);
    chk("R4", "op", 64'(rd_op), 64'(op));
    chk("R5", "aw", 64'(rd_aw), 64'(aw));
    chk(req, "addr", 64'(rd_addr), 64'(a));
    chk(req, "data", 64'(rd_data), 64'(d));
    chk("R3", "idx", 64'(rd_idx), 64'(ix));
    chk("R2", "dur", 64'(rd_dur), 64'(du));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_bus();
    repeat (3) @(negedge clk);
    chk("R11", "triggered", 64'(triggered), 64'd0);
    chk("R11", "done", 64'(done), 64'd0);
    chk("R11", "rd_valid", 64'(rd_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t exp_q [$];
    logic [7:0] exp_idx [$];
    bit trig_m = 0, done_m = 0;
    int post_m = 0;
    int n;

    rst_n = 1'b0; rd_en = 1'b0;
    idle_bus();
    am = '0; addr = '0; data = '0;
    cfg_addr = CA; cfg_addr_mask = CM;
    cfg_data = '0; cfg_data_mask = '0;
    cfg_am = '0; cfg_am_mask = '0;
    cfg_post = POST;
    do_reset();

    // table walk: trigger by address match, post-trigger count, done
    for (int i = 0; i < 8; i++) begin
      bus_cycle(TABLE[i]);
      if (!done_m) begin
        if (trig_m) begin
          exp_q.push_back(TABLE[i]); exp_idx.push_back(8'(i));
          post_m++;
          if (post_m == int'(POST)) done_m = 1;
        end else if ((((TABLE[i].addr ^ CA) & CM) == 0) || TABLE[i].berr) begin
          trig_m = 1;
          exp_q.push_back(TABLE[i]); exp_idx.push_back(8'(i));
          if (POST == 0) done_m = 1;
        end
      end
      chk("R6", "triggered", 64'(triggered), 64'(trig_m));
      chk("R9", "done", 64'(done), 64'(done_m));
      if (i == 1) chk("R8", "no record before trigger", 64'(rd_valid), 64'd0);
    end

    n = 0;
    while (rd_valid && n < 10) begin
      read_rec("R10", exp_q[n].op, exp_q[n].aw, exp_q[n].addr, exp_q[n].data,
               exp_idx[n], 8'(exp_q[n].gap));
      n++;
    end
    chk("R9", "records stored", 64'(n), 64'(exp_q.size()));
    chk("R10", "drained", 64'(rd_valid), 64'd0);

    // directed: forced trigger on bus error with impossible match, saturation
    cfg_addr = 32'hFFFF_FFFF; cfg_addr_mask = 32'hFFFF_FFFF;
    cfg_post = PW'(2);
    do_reset();
    bus_cycle('{6'h01, 32'h0000_0100, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1,
                10'd300, 3'd5, 3'd4});
    chk("R7", "berr forces trigger", 64'(triggered), 64'd1);
    read_rec("R7", 3'd5, 3'd4, 32'h0000_0100, 32'h0000_0001, 8'd0, 8'd255);

    // directed: read then write under one address strobe
    @(negedge clk);
    am = 6'h09; addr = 32'h0000_0800; data = 32'h0000_00C3;
    repeat (2) @(negedge clk);
    as_n = 1'b0; ds_n = 1'b0;
    repeat (3) @(negedge clk);
    dtack_n = 1'b0;
    repeat (3) @(negedge clk);
    ds_n = 1'b1; dtack_n = 1'b1;
    repeat (2) @(negedge clk);
    write_n = 1'b0; ds_n = 1'b0;
    repeat (2) @(negedge clk);
    dtack_n = 1'b0;
    repeat (6) @(negedge clk);
    idle_bus();
    repeat (6) @(negedge clk);
    chk("R9", "done after post records", 64'(done), 64'd1);
    read_rec("R4", 3'd0, 3'd2, 32'h0000_0800, 32'h0000_00C3, 8'd1, 8'd3);
    read_rec("R4", 3'd2, 3'd2, 32'h0000_0800, 32'h0000_00C3, 8'd2, 8'd10);
    chk("R1", "one record per termination", 64'(rd_valid), 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule